// File: doc/BRIEF.md
# Seven-Segment Digit Row with Ripple Zero Blanking

This block turns a row of BCD digits into segment drive for a common-anode display. The segment outputs are active low: 0 lights a segment and 1 turns it off. Each digit stage has an active-low blanking input and an active-low blanking output. A zero digit goes dark only when its blanking input is asserted. It then asserts its own blanking output, so the next stage in the chain may also drop a zero. Zeros that sit between nonzero digits are still shown.

The top level builds the chain for any number of digits. A mode input selects the direction of the chain. In leading mode the chain starts at the most significant digit and runs toward the units digit. In trailing mode it starts at the least significant digit and runs upward. A per-digit mask forces chosen digits to stay visible, for example the units digit of an integer part. The segment lines and the final blanking output are registered once. A synchronous active-high reset clears them.

Top module: `seg_blank_display`

## Requirements
- R1: Segment lanes are active low and ordered a..g from MSB to LSB. With no blanking, codes 0..9 give 0000001, 1001111, 0010010, 0000110, 1001100, 0100100, 1100000, 0001111, 0000000 and 0001100.
- R2: Codes 1010..1111 turn all seven segments of that digit off (1111111), whatever the chain state.
- R3: A digit holding 0000 with its blanking input at 0 shows 1111111 and drives its blanking output to 0.
- R4: A digit holding 0000 with its blanking input at 1 shows the 0 glyph 0000001.
- R5: A digit's blanking output is 1 whenever its blanking input is 1 or its code is not 0000, and a code 1..9 is never blanked.
- R6: With `trailing_mode`=0 the chain starts at digit NUM_DIGITS-1 with its input at 0. Each stage's output feeds the next less significant digit. Digit 0 is the least significant, on `bcd_in[3:0]`, and digit i is on `bcd_in[4i+3:4i]` and `seg_n_out[7i+6:7i]`.
- R7: With `trailing_mode`=1 the chain starts at digit 0 with its input at 0. Each stage's output feeds the next more significant digit.
- R8: `show_mask[i]`=1 forces digit i's blanking input to 1, so a valid code on that digit is always shown.
- R9: `chain_rbo_n` is the blanking output of the last stage in the chain, which is digit 0 in leading mode and digit NUM_DIGITS-1 in trailing mode. It is 1 whenever any digit code is nonzero.
- R10: Outputs are registered with one cycle of latency. A cycle with `rst`=1 makes every segment 1 and `chain_rbo_n` 1 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trailing_mode | input | 1 | 0 = leading-zero chain, 1 = trailing-zero chain |
| show_mask | input | NUM_DIGITS | Per-digit force-visible bits |
| bcd_in | input | 4*NUM_DIGITS | Packed BCD digits, digit 0 in the low nibble |
| seg_n_out | output | 7*NUM_DIGITS | Registered active-low segments, a..g per digit lane |
| chain_rbo_n | output | 1 | Registered blanking output of the last chain stage |

## Verification
The bench builds the block with NUM_DIGITS=4. Four digits are enough for the chain to hold an interior zero between two nonzero digits and a run of two zeros at either end, and to show both chain directions ending on different physical digits. The most significant digit goes through every code with both blanking-input levels. In leading mode that digit starts the chain, so the mask alone sets its input, and the three zero digits behind it show whether the blanking output carried down the chain.

// File: rtl/seg_disp_pkg.sv
package seg_disp_pkg;
  localparam int SEG_W = 7;
  localparam int BCD_W = 4;

  typedef logic [SEG_W-1:0] seg_t;

  localparam seg_t SEG_DARK = '1;

  // active-low glyphs, bit 6 = a ... bit 0 = g
  function automatic seg_t glyph_of(input logic [BCD_W-1:0] code);
    seg_t g;
    case (code)
      4'd0: g = 7'b0000001;
      4'd1: g = 7'b1001111;
      4'd2: g = 7'b0010010;
      4'd3: g = 7'b0000110;
      4'd4: g = 7'b1001100;
      4'd5: g = 7'b0100100;
      4'd6: g = 7'b1100000;
      4'd7: g = 7'b0001111;
      4'd8: g = 7'b0000000;
      4'd9: g = 7'b0001100;
      default: g = SEG_DARK;
    endcase
    return g;
  endfunction
endpackage

// File: rtl/seg_digit_dec.sv
module seg_digit_dec
  import seg_disp_pkg::*;
(
  input  logic [BCD_W-1:0] code,
  input  logic             blank_in_n,
  output seg_t             seg_n,
  output logic             blank_out_n
);
  logic is_zero;
  logic suppress;

  assign is_zero  = (code == '0);
  assign suppress = is_zero & ~blank_in_n;

  always_comb begin
    if (suppress) begin
      seg_n       = SEG_DARK;
      blank_out_n = 1'b0;
    end else begin
      seg_n       = glyph_of(code);
      blank_out_n = 1'b1;
    end
  end

  // R3
  always_comb begin
    if (blank_out_n === 1'b0) begin
      dark_when_pass_chk: assert (seg_n == SEG_DARK);
    end
  end
endmodule

// File: rtl/seg_lane_swap.sv
module seg_lane_swap #(
  parameter int LANES = 4,
  parameter int WIDTH = 4
) (
  input  logic                   reverse,
  input  logic [LANES*WIDTH-1:0] din,
  output logic [LANES*WIDTH-1:0] dout
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    localparam int MIRROR = LANES - 1 - j;
    assign dout[j*WIDTH +: WIDTH] = reverse ? din[MIRROR*WIDTH +: WIDTH]
                                            : din[j*WIDTH +: WIDTH];
  end
endmodule

// File: rtl/seg_blank_display.sv
module seg_blank_display
  import seg_disp_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        trailing_mode,
  input  logic [NUM_DIGITS-1:0]       show_mask,
  input  logic [NUM_DIGITS*BCD_W-1:0] bcd_in,
  output logic [NUM_DIGITS*SEG_W-1:0] seg_n_out,
  output logic                        chain_rbo_n
);
  localparam int BCD_BITS = NUM_DIGITS * BCD_W;
  localparam int SEG_BITS = NUM_DIGITS * SEG_W;
  localparam int LAST     = NUM_DIGITS - 1;

  // chain position 0 is the stage with its blanking input tied low
  logic                  reverse;
  logic [BCD_BITS-1:0]   chain_bcd;
  logic [NUM_DIGITS-1:0] chain_mask;
  logic [SEG_BITS-1:0]   chain_seg;
  logic [SEG_BITS-1:0]   digit_seg;
  logic                  chain_end_n;

  assign reverse = ~trailing_mode;

  seg_lane_swap #(.LANES(NUM_DIGITS), .WIDTH(BCD_W)) i_bcd_swap (
    .reverse (reverse),
    .din     (bcd_in),
    .dout    (chain_bcd)
  );

  seg_lane_swap #(.LANES(NUM_DIGITS), .WIDTH(1)) i_mask_swap (
    .reverse (reverse),
    .din     (show_mask),
    .dout    (chain_mask)
  );

  for (genvar j = 0; j < NUM_DIGITS; j++) begin : g_stage
    logic blank_in_n;
    logic blank_out_n;
    seg_t stage_seg;
    if (j == 0) begin : g_head
      assign blank_in_n = chain_mask[0];
    end else begin : g_link
      assign blank_in_n = g_stage[j-1].blank_out_n | chain_mask[j];
    end
    seg_digit_dec i_dec (
      .code        (chain_bcd[j*BCD_W +: BCD_W]),
      .blank_in_n  (blank_in_n),
      .seg_n       (stage_seg),
      .blank_out_n (blank_out_n)
    );
    assign chain_seg[j*SEG_W +: SEG_W] = stage_seg;
  end

  assign chain_end_n = g_stage[LAST].blank_out_n;

  seg_lane_swap #(.LANES(NUM_DIGITS), .WIDTH(SEG_W)) i_seg_swap (
    .reverse (reverse),
    .din     (chain_seg),
    .dout    (digit_seg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_n_out   <= '1;
      chain_rbo_n <= 1'b1;
    end else begin
      seg_n_out   <= digit_seg;
      chain_rbo_n <= chain_end_n;
    end
  end

  // R10
  reset_dark_chk: assert property (@(posedge clk)
    rst |=> (seg_n_out == '1) && chain_rbo_n);

  // R9
  chain_live_chk: assert property (@(posedge clk) disable iff (rst)
    (bcd_in != '0) |=> chain_rbo_n);

  // R3
  all_dark_chk: assert property (@(posedge clk) disable iff (rst)
    ((bcd_in == '0) && (show_mask == '0)) |=> ((seg_n_out == '1) && !chain_rbo_n));

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_chk
    // R2
    invalid_dark_chk: assert property (@(posedge clk) disable iff (rst)
      (bcd_in[i*BCD_W +: BCD_W] > 4'd9) |=> (seg_n_out[i*SEG_W +: SEG_W] == SEG_DARK));
    // R5
    nonzero_lit_chk: assert property (@(posedge clk) disable iff (rst)
      ((bcd_in[i*BCD_W +: BCD_W] != 4'd0) && (bcd_in[i*BCD_W +: BCD_W] <= 4'd9))
      |=> (seg_n_out[i*SEG_W +: SEG_W] != SEG_DARK));
    // R8
    forced_lit_chk: assert property (@(posedge clk) disable iff (rst)
      (show_mask[i] && (bcd_in[i*BCD_W +: BCD_W] <= 4'd9))
      |=> (seg_n_out[i*SEG_W +: SEG_W] != SEG_DARK));
  end
endmodule

// File: tb/test_seg_blank_display.sv
`timescale 1ns/1ps
module test_seg_blank_display;
  localparam int ND = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          trailing_mode = 1'b0;
  logic [ND-1:0] show_mask = '0;
  logic [15:0]   bcd_in = '0;
  logic [27:0]   seg_n_out;
  logic          chain_rbo_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  seg_blank_display #(.NUM_DIGITS(ND)) i_seg_blank_display (
    .clk           (clk),
    .rst           (rst),
    .trailing_mode (trailing_mode),
    .show_mask     (show_mask),
    .bcd_in        (bcd_in),
    .seg_n_out     (seg_n_out),
    .chain_rbo_n   (chain_rbo_n)
  );

  // spec glyphs from R1, dark for R2 codes
  function automatic logic [6:0] spec_glyph(input int c);
    case (c)
      0: return 7'b0000001;
      1: return 7'b1001111;
      2: return 7'b0010010;
      3: return 7'b0000110;
      4: return 7'b1001100;
      5: return 7'b0100100;
      6: return 7'b1100000;
      7: return 7'b0001111;
      8: return 7'b0000000;
      9: return 7'b0001100;
      default: return 7'h7F;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [27:0] exp_s, input logic exp_c);
    checks++;
    if (seg_n_out !== exp_s || chain_rbo_n !== exp_c) begin
      failures++;
      $display("FAIL %s: seg=%h rbo=%b expected seg=%h rbo=%b",
               tag, seg_n_out, chain_rbo_n, exp_s, exp_c);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // {trailing, mask[3:0], bcd d3..d0, seg d3..d0, chain}
  localparam int NV = 12;
  localparam logic [49:0] VEC [NV] = '{
    {1'b0, 4'b0000, 16'h0050, 7'h7F, 7'h7F, 7'h24, 7'h01, 1'b1}, // R6
    {1'b1, 4'b0000, 16'h0050, 7'h01, 7'h01, 7'h24, 7'h7F, 1'b1}, // R7
    {1'b0, 4'b0000, 16'h0900, 7'h7F, 7'h0C, 7'h01, 7'h01, 1'b1}, // R6
    {1'b1, 4'b0000, 16'h0900, 7'h01, 7'h0C, 7'h7F, 7'h7F, 1'b1}, // R7
    {1'b0, 4'b0000, 16'h0000, 7'h7F, 7'h7F, 7'h7F, 7'h7F, 1'b0}, // R3
    {1'b0, 4'b0001, 16'h0000, 7'h7F, 7'h7F, 7'h7F, 7'h01, 1'b1}, // R8
    {1'b1, 4'b1000, 16'h0000, 7'h01, 7'h7F, 7'h7F, 7'h7F, 1'b1}, // R8
    {1'b0, 4'b0100, 16'h0000, 7'h7F, 7'h01, 7'h01, 7'h01, 1'b1}, // R8
    {1'b0, 4'b0000, 16'h1030, 7'h4F, 7'h01, 7'h06, 7'h01, 1'b1}, // R6
    {1'b1, 4'b0000, 16'h1030, 7'h4F, 7'h01, 7'h06, 7'h7F, 1'b1}, // R7
    {1'b0, 4'b0000, 16'h0A00, 7'h7F, 7'h7F, 7'h01, 7'h01, 1'b1}, // R2
    {1'b1, 4'b0000, 16'h0000, 7'h7F, 7'h7F, 7'h7F, 7'h7F, 1'b0}  // R9
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick();
    tick();
    chk("R10 reset state", 28'hFFFFFFF, 1'b1);
    rst = 1'b0;

    // every code on digit 3, both blanking-input levels (R1 R2 R3 R4 R5)
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 2; f++) begin
        logic [6:0]  top;
        logic        pass_n;
        logic [6:0]  rest;
        string       tag;
        trailing_mode = 1'b0;
        show_mask     = {f[0], 3'b000};
        bcd_in        = {4'(c), 12'h000};
        pass_n = (c != 0) || (f != 0);
        top    = (c == 0 && f == 0) ? 7'h7F : spec_glyph(c);
        rest   = pass_n ? 7'h01 : 7'h7F;
        if (c == 0) tag = (f != 0) ? "R4 zero shown" : "R3 zero blanked";
        else if (c > 9) tag = "R2 invalid code";
        else tag = "R1 glyph R5 pass";
        tick();
        chk(tag, {top, rest, rest, rest}, pass_n);
      end
    end

    for (int v = 0; v < NV; v++) begin
      trailing_mode = VEC[v][49];
      show_mask     = VEC[v][48:45];
      bcd_in        = VEC[v][44:29];
      tick();
      chk($sformatf("R6 R7 R8 R9 chain vector %0d", v), VEC[v][28:1], VEC[v][0]);
    end

    // R10 latency: output holds until the edge
    trailing_mode = 1'b0;
    show_mask = '0;
    bcd_in = 16'h0050;
    tick();
    bcd_in = 16'h1111;
    #0.5;
    chk("R10 holds before edge", {7'h7F, 7'h7F, 7'h24, 7'h01}, 1'b1);
    tick();
    chk("R10 updates after edge", {7'h4F, 7'h4F, 7'h4F, 7'h4F}, 1'b1);

    // R10 mid-run reset
    rst = 1'b1;
    tick();
    chk("R10 reset mid-run", 28'hFFFFFFF, 1'b1);
    rst = 1'b0;
    tick();
    chk("R1 after reset release", {7'h4F, 7'h4F, 7'h4F, 7'h4F}, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule